// File: doc/BRIEF.md
# Prefixed Extension Opcode Extractor

This block sits in the dispatch stage of a VLIW DSP core. The core issues variable-length execution sets made of 16-bit words. Each cycle the block takes one execution set and looks for the single two-word extension opcode addressed to an attached accelerator. When it finds one in a legal position, it joins the free bits of the two words into a 25-bit payload. The top bits of the payload are split off as an accelerator-select field, and the rest is handed to the chosen accelerator over a valid/ready interface.

Each execution set arrives with three qualifiers:
- a per-word valid mask,
- a per-word opcode-start mask,
- a flag saying whether the set carries a prefix grouping.

An opcode that breaks the placement or encoding rules is not forwarded. Instead it sets one of four sticky error flags. The flags stay set until a clear pulse arrives. The output holds stable while the accelerator is not ready, and the block refuses new sets during that time.

Top module: `xop_extract`

## Requirements
- R1: An extension opcode is recognised as follows.
  - Its header word has bits [15:12] = 4'b0011, is valid, is marked as an opcode start, and is not the first opcode of the set.
  - The next word is valid and has bits [15:13] = 3'b101.
  - When the set also carries a prefix, the block forwards the opcode one cycle after the set is accepted.
  - The payload is {header[11:0], tail[12:0]}, 25 bits.
- R2: A header pattern at the first opcode of the set is treated as an ordinary core opcode. The first opcode is the lowest word that is both valid and start-marked. Such a pattern produces no output and no error.
- R3: With SEL_BITS = 2, `acc_sel_o` is payload[24:23] and `acc_insn_o` is payload[22:0]. With SEL_BITS = 0, the select is 0 and the whole payload is the instruction.
- R4: Two or more well-formed extension opcodes in one prefixed set set error bit 2 (multiple). Only the lowest-positioned one is forwarded.
- R5: A well-formed extension opcode in a set without a prefix sets error bit 1 (no prefix), and nothing is forwarded.
- R6: Error bit 0 (malformed) is set, and that opcode is not forwarded, in two cases:
  - a non-first header whose next word does not start with 3'b101;
  - a non-first header that is the last valid word of the set, including the top word position.
- R7: A select value of NUM_ACCEL or more (default 3) sets error bit 3 (unmapped), and `acc_valid_o` stays low.
- R8: While `acc_valid_o` is high and `acc_ready_i` is low, the output stays unchanged and `set_ready_o` is low. A set offered during that time is not taken.
- R9: Reset (`rst_ni` low, asynchronous) clears `acc_valid_o` and all error flags.
- R10: Error flags are sticky. `err_clr_i` clears them, but an error raised in the same cycle as the clear is kept.
- R11: Words whose valid bit is low, and header patterns on words not marked as opcode starts, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| set_valid_i | input | 1 | An execution set is presented |
| set_ready_o | output | 1 | Block can take a set this cycle |
| words_i | input | 16*NUM_WORDS | Set words, word i at bits [16i+15:16i] |
| word_vld_i | input | NUM_WORDS | Per-word valid mask |
| op_start_i | input | NUM_WORDS | Per-word opcode-start mask |
| prefix_i | input | 1 | Set carries a prefix grouping |
| err_clr_i | input | 1 | Clear pulse for the sticky error flags |
| acc_ready_i | input | 1 | Accelerator accepts the output |
| acc_valid_o | output | 1 | Extension instruction valid |
| acc_sel_o | output | max(SEL_BITS,1) | Accelerator select |
| acc_insn_o | output | 25-SEL_BITS | Instruction bits for the accelerator |
| err_o | output | 4 | Sticky flags: [0] malformed, [1] no prefix, [2] multiple, [3] unmapped |

## Verification
A wrong "first opcode" choice shows up one cycle after the set is accepted, in either of two ways. A first-position pattern appears on `acc_valid_o`, or a legal non-first opcode is dropped. A wrong priority pick shows in that same cycle as the later opcode's select and instruction on the outputs. A lost or stuck error flag shows on `err_o` right after the accepting edge, and it stays visible across idle cycles until a clear. A broken stall shows within one edge, as output values that change while `acc_ready_i` is low.

// File: rtl/xop_pkg.sv
`timescale 1ns/1ps
package xop_pkg;
  localparam int WORD_W    = 16;
  localparam int PAYLOAD_W = 25;
  localparam int HDR_FREE  = 12;
  localparam int TAIL_FREE = 13;
  localparam int ERR_N     = 4;

  localparam logic [3:0] HDR_TAG  = 4'b0011;
  localparam logic [2:0] TAIL_TAG = 3'b101;

  typedef enum int {
    ERR_MALFORMED = 0,
    ERR_NO_PREFIX = 1,
    ERR_MULTI     = 2,
    ERR_UNMAPPED  = 3
  } err_idx_e;
endpackage

// File: rtl/xop_word_match.sv
`timescale 1ns/1ps
module xop_word_match
  import xop_pkg::*;
(
  input  logic [WORD_W-1:0]    hdr_word_i,
  input  logic [WORD_W-1:0]    nxt_word_i,
  input  logic                 hdr_vld_i,
  input  logic                 nxt_vld_i,
  input  logic                 hdr_start_i,
  input  logic                 is_first_i,
  output logic                 ext_o,
  output logic                 bad_o,
  output logic [PAYLOAD_W-1:0] payload_o
);
  logic hdr_hit, tail_ok;

  // First-position pattern is a core opcode, not an extension.
  assign hdr_hit   = hdr_vld_i && hdr_start_i && !is_first_i &&
                     (hdr_word_i[WORD_W-1 -: 4] == HDR_TAG);
  assign tail_ok   = nxt_vld_i && (nxt_word_i[WORD_W-1 -: 3] == TAIL_TAG);
  assign ext_o     = hdr_hit && tail_ok;
  assign bad_o     = hdr_hit && !tail_ok;
  assign payload_o = {hdr_word_i[HDR_FREE-1:0], nxt_word_i[TAIL_FREE-1:0]};
endmodule

// File: rtl/xop_scan.sv
`timescale 1ns/1ps
module xop_scan
  import xop_pkg::*;
#(
  parameter int NUM_WORDS = 8
) (
  input  logic [NUM_WORDS*WORD_W-1:0] words_i,
  input  logic [NUM_WORDS-1:0]        word_vld_i,
  input  logic [NUM_WORDS-1:0]        op_start_i,
  output logic                        found_o,
  output logic                        multi_o,
  output logic                        malformed_o,
  output logic [PAYLOAD_W-1:0]        payload_o
);
  localparam logic [NUM_WORDS-1:0] ONE = {{(NUM_WORDS-1){1'b0}}, 1'b1};

  logic [NUM_WORDS-1:0] starts, first_mask, ext, bad;
  logic [PAYLOAD_W-1:0] pay [NUM_WORDS];

  assign starts     = word_vld_i & op_start_i;
  assign first_mask = starts & ~(starts - ONE);

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_pos
    logic [WORD_W-1:0] nxt_word;
    logic              nxt_vld;
    if (i == NUM_WORDS - 1) begin : g_top
      assign nxt_word = '0;
      assign nxt_vld  = 1'b0;
    end else begin : g_mid
      assign nxt_word = words_i[(i+1)*WORD_W +: WORD_W];
      assign nxt_vld  = word_vld_i[i+1];
    end
    xop_word_match u_match (
      .hdr_word_i (words_i[i*WORD_W +: WORD_W]),
      .nxt_word_i (nxt_word),
      .hdr_vld_i  (word_vld_i[i]),
      .nxt_vld_i  (nxt_vld),
      .hdr_start_i(op_start_i[i]),
      .is_first_i (first_mask[i]),
      .ext_o      (ext[i]),
      .bad_o      (bad[i]),
      .payload_o  (pay[i])
    );
  end

  // Downward walk leaves the lowest-positioned opcode selected.
  always_comb begin
    payload_o = '0;
    for (int i = NUM_WORDS - 1; i >= 0; i--) begin
      if (ext[i]) payload_o = pay[i];
    end
  end

  assign found_o     = |ext;
  assign multi_o     = |(ext & (ext - ONE));
  assign malformed_o = |bad;
endmodule

// File: rtl/xop_sel_split.sv
`timescale 1ns/1ps
module xop_sel_split
  import xop_pkg::*;
#(
  parameter int SEL_BITS  = 2,
  parameter int NUM_ACCEL = 3,
  localparam int SEL_W    = (SEL_BITS > 0) ? SEL_BITS : 1,
  localparam int INSN_W   = PAYLOAD_W - SEL_BITS
) (
  input  logic [PAYLOAD_W-1:0] payload_i,
  output logic [SEL_W-1:0]     sel_o,
  output logic [INSN_W-1:0]    insn_o,
  output logic                 mapped_o
);
  if (SEL_BITS == 0) begin : g_single
    assign sel_o    = '0;
    assign insn_o   = payload_i;
    assign mapped_o = 1'b1;
  end else begin : g_multi
    assign sel_o    = payload_i[PAYLOAD_W-1 -: SEL_BITS];
    assign insn_o   = payload_i[INSN_W-1:0];
    assign mapped_o = (32'(sel_o) < NUM_ACCEL);
  end
endmodule

// File: rtl/xop_err_reg.sv
`timescale 1ns/1ps
module xop_err_reg #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (clr_i ? '0 : flags_o) | set_i;
  end

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> (flags_o == '0));
endmodule

// File: rtl/xop_extract.sv
`timescale 1ns/1ps
module xop_extract
  import xop_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int SEL_BITS  = 2,
  parameter int NUM_ACCEL = 3,
  localparam int SEL_W    = (SEL_BITS > 0) ? SEL_BITS : 1,
  localparam int INSN_W   = PAYLOAD_W - SEL_BITS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        set_valid_i,
  output logic                        set_ready_o,
  input  logic [NUM_WORDS*WORD_W-1:0] words_i,
  input  logic [NUM_WORDS-1:0]        word_vld_i,
  input  logic [NUM_WORDS-1:0]        op_start_i,
  input  logic                        prefix_i,
  input  logic                        err_clr_i,
  input  logic                        acc_ready_i,
  output logic                        acc_valid_o,
  output logic [SEL_W-1:0]            acc_sel_o,
  output logic [INSN_W-1:0]           acc_insn_o,
  output logic [ERR_N-1:0]            err_o
);
  logic                 found, multi, malformed, mapped, accept, fwd;
  logic [PAYLOAD_W-1:0] payload;
  logic [SEL_W-1:0]     sel;
  logic [INSN_W-1:0]    insn;
  logic [ERR_N-1:0]     new_err;

  xop_scan #(.NUM_WORDS(NUM_WORDS)) u_scan (
    .words_i    (words_i),
    .word_vld_i (word_vld_i),
    .op_start_i (op_start_i),
    .found_o    (found),
    .multi_o    (multi),
    .malformed_o(malformed),
    .payload_o  (payload)
  );

  xop_sel_split #(.SEL_BITS(SEL_BITS), .NUM_ACCEL(NUM_ACCEL)) u_split (
    .payload_i(payload),
    .sel_o    (sel),
    .insn_o   (insn),
    .mapped_o (mapped)
  );

  assign set_ready_o = !acc_valid_o || acc_ready_i;
  assign accept      = set_valid_i && set_ready_o;
  assign fwd         = accept && prefix_i && found && mapped;

  always_comb begin
    new_err                = '0;
    new_err[ERR_MALFORMED] = accept && malformed;
    new_err[ERR_NO_PREFIX] = accept && found && !prefix_i;
    new_err[ERR_MULTI]     = accept && prefix_i && multi;
    new_err[ERR_UNMAPPED]  = accept && prefix_i && found && !mapped;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_valid_o <= 1'b0;
      acc_sel_o   <= '0;
      acc_insn_o  <= '0;
    end else if (accept) begin
      acc_valid_o <= fwd;
      if (fwd) begin
        acc_sel_o  <= sel;
        acc_insn_o <= insn;
      end
    end else if (acc_ready_i) begin
      acc_valid_o <= 1'b0;
    end
  end

  xop_err_reg #(.N(ERR_N)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (err_clr_i),
    .set_i  (new_err),
    .flags_o(err_o)
  );

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_o && !acc_ready_i) |=>
      (acc_valid_o && $stable(acc_sel_o) && $stable(acc_insn_o)));
  p_mapped_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_o |-> (32'(acc_sel_o) < NUM_ACCEL));
  p_prefix_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acc_valid_o) |-> $past(set_valid_i && prefix_i));
  p_no_err_on_fwd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && fwd) |=> !err_o[ERR_UNMAPPED] || $past(err_o[ERR_UNMAPPED] && !err_clr_i));
endmodule

// File: tb/xop_extract_test.sv
`timescale 1ns/1ps
module xop_extract_test;
  localparam logic [15:0] C = 16'h9000;
  localparam logic [15:0] Z = 16'h0000;

  typedef struct packed {
    logic [127:0] words;
    logic [7:0]   vld;
    logic [7:0]   start;
    logic         pre;
    logic         ev;
    logic [1:0]   es;
    logic [22:0]  ei;
    logic [3:0]   ee;
  } vec_t;

  // Payloads: A sel1/0x012345 -> 3409,A345; B sel2/0x7FFFFF -> 3BFF,BFFF;
  // U sel3/0x000001 -> 3C00,A001; D sel0/0x000ABC -> 3000,AABC.
  localparam vec_t TBL [12] = '{
    '{{Z,Z,Z,Z,C,16'hA345,16'h3409,C}, 8'h0F, 8'h0B, 1'b1, 1'b1, 2'd1, 23'h012345, 4'b0000}, // R1
    '{{Z,Z,Z,16'hBFFF,16'h3BFF,C,C,C}, 8'h1F, 8'h0F, 1'b1, 1'b1, 2'd2, 23'h7FFFFF, 4'b0000}, // R3
    '{{Z,Z,Z,Z,Z,C,16'hA345,16'h3409}, 8'h07, 8'h05, 1'b1, 1'b0, 2'd0, 23'h0, 4'b0000},       // R2
    '{{Z,Z,C,16'hBFFF,16'h3BFF,16'hAABC,16'h3000,C}, 8'h3F, 8'h2B, 1'b1, 1'b1, 2'd0, 23'h000ABC, 4'b0100}, // R4
    '{{Z,Z,Z,Z,C,16'hA345,16'h3409,C}, 8'h0F, 8'h0B, 1'b0, 1'b0, 2'd0, 23'h0, 4'b0010},       // R5
    '{{Z,Z,Z,Z,Z,C,16'h3409,C}, 8'h07, 8'h07, 1'b1, 1'b0, 2'd0, 23'h0, 4'b0001},             // R6 bad tail
    '{{Z,Z,Z,Z,Z,Z,16'h3409,C}, 8'h03, 8'h03, 1'b1, 1'b0, 2'd0, 23'h0, 4'b0001},             // R6 last word
    '{{Z,Z,Z,Z,Z,16'hA001,16'h3C00,C}, 8'h07, 8'h03, 1'b1, 1'b0, 2'd0, 23'h0, 4'b1000},      // R7
    '{{Z,Z,Z,Z,Z,16'hA345,16'h3409,C}, 8'h01, 8'h03, 1'b1, 1'b0, 2'd0, 23'h0, 4'b0000},      // R11 invalid
    '{{16'hAABC,16'h3000,C,C,C,C,C,C}, 8'hFF, 8'h7F, 1'b1, 1'b1, 2'd0, 23'h000ABC, 4'b0000}, // R1 top pair
    '{{Z,Z,Z,Z,Z,16'hA345,16'h3409,C}, 8'h07, 8'h01, 1'b1, 1'b0, 2'd0, 23'h0, 4'b0000},      // R11 no start
    '{{16'h3409,C,C,C,C,C,C,C}, 8'hFF, 8'h81, 1'b1, 1'b0, 2'd0, 23'h0, 4'b0001}              // R6 top word
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         set_valid = 1'b0;
  logic         set_ready;
  logic [127:0] words = '0;
  logic [7:0]   vld = '0;
  logic [7:0]   start = '0;
  logic         pre = 1'b0;
  logic         clr = 1'b0;
  logic         ready = 1'b1;
  logic         valid;
  logic [1:0]   sel;
  logic [22:0]  insn;
  logic [3:0]   err;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  xop_extract uut (
    .clk_i(clk), .rst_ni(rst_n), .set_valid_i(set_valid), .set_ready_o(set_ready),
    .words_i(words), .word_vld_i(vld), .op_start_i(start), .prefix_i(pre),
    .err_clr_i(clr), .acc_ready_i(ready), .acc_valid_o(valid), .acc_sel_o(sel),
    .acc_insn_o(insn), .err_o(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic c);
    words = v.words; vld = v.vld; start = v.start; pre = v.pre;
    clr = c; set_valid = 1'b1;
  endtask

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #12;
    check("R9 reset valid", 32'(valid), 0);
    check("R9 reset err", 32'(err), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle ready", 32'(set_ready), 1);

    for (int i = 0; i < 12; i++) begin
      drive(TBL[i], 1'b1);
      @(negedge clk);
      set_valid = 1'b0; clr = 1'b0;
      check($sformatf("vec%0d valid", i), 32'(valid), 32'(TBL[i].ev));
      if (TBL[i].ev) begin
        check($sformatf("vec%0d R3 sel", i), 32'(sel), 32'(TBL[i].es));
        check($sformatf("vec%0d R3 insn", i), 32'(insn), 32'(TBL[i].ei));
      end
      check($sformatf("vec%0d err", i), 32'(err), 32'(TBL[i].ee));
      @(negedge clk);
    end

    // R8 stall: hold output, refuse new set
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    ready = 1'b0;
    drive(TBL[0], 1'b0);
    @(negedge clk);
    drive(TBL[1], 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 hold valid", 32'(valid), 1);
      check("R8 hold sel", 32'(sel), 1);
      check("R8 hold insn", 32'(insn), 32'h012345);
      check("R8 stall ready", 32'(set_ready), 0);
    end
    ready = 1'b1;
    @(negedge clk);
    set_valid = 1'b0;
    check("R8 next taken sel", 32'(sel), 2);
    check("R8 next taken insn", 32'(insn), 32'h7FFFFF);
    @(negedge clk);
    check("R8 drain", 32'(valid), 0);

    // R10 sticky accumulate and clear
    drive(TBL[5], 1'b0); @(negedge clk); set_valid = 1'b0;
    check("R10 first flag", 32'(err), 32'h1);
    drive(TBL[4], 1'b0); @(negedge clk); set_valid = 1'b0;
    check("R10 accumulate", 32'(err), 32'h3);
    repeat (4) @(negedge clk);
    check("R10 sticky idle", 32'(err), 32'h3);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    check("R10 clear", 32'(err), 32'h0);

    // R9 async reset mid-run
    drive(TBL[7], 1'b0); @(negedge clk);
    drive(TBL[0], 1'b0); @(negedge clk); set_valid = 1'b0;
    ready = 1'b0;
    #1 rst_n = 1'b0; #1;
    check("R9 async valid", 32'(valid), 0);
    check("R9 async err", 32'(err), 0);
    @(negedge clk); rst_n = 1'b1; ready = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule